// File: doc/BRIEF.md
# Transmit Mailbox Arbiter

This block decides which of 32 message mailboxes a CAN-style controller sends next. Each mailbox has an enable bit, a direction bit and a 14-bit control word. Bits 13:8 of the control word hold a 6-bit priority level. Software asks for transmission by writing a bit mask to a set-request port.

Among the mailboxes that are pending, enabled and set to transmit, the arbiter picks the one with the highest priority level. When levels are equal, the higher mailbox number wins. It offers the winning index to a frame serializer over a request/done handshake.

When a frame completes, the arbiter does four things:
- it clears that mailbox's pending bit;
- it sets the mailbox's acknowledge bit;
- if the mailbox's interrupt mask bit is 1, it raises a mailbox interrupt flag;
- it records the mailbox index alongside the flag.

Abort requests cancel pending mailboxes that are not in flight and report them in a separate abort-acknowledge vector. Software clears the acknowledge, abort-acknowledge and interrupt state with write-one strobes.

Top module: `txMailboxArbiter`

## Requirements
- R1: A mailbox can be selected only when its pending bit is 1, its enable bit is 1 and its direction bit is 0 (direction 1 means receive). Pending mailboxes that are disabled or set to receive never raise `txReq`.
- R2: Among candidates, the mailbox whose priority field (control word bits 13:8) is numerically largest is selected. Control word bits 7:0 have no effect on selection.
- R3: When several candidates share the largest priority field, the highest-numbered mailbox is selected.
- R4: A `setWr` strobe ORs `setMask` into the pending vector. Mask bits at 0 leave the other pending bits unchanged. Pending bits are visible one cycle after the strobe.
- R5: Selection happens only while no frame is in flight. While `txReq` is 1 and `txDone` is 0, `txReq` stays 1 and `txIndex` is held, even if a higher-priority request arrives. A new selection can start in the cycle after completion, so `txReq` rises again two cycles after `txDone`.
- R6: `txDone` with `txReq` high clears the pending bit of `txIndex` and sets its `ackBits` bit. An `ackClrWr` strobe clears exactly the `ackBits` positions that are 1 in `ackClrMask`.
- R7: An `abortWr` strobe clears the pending bits selected by `abortMask` and sets the matching `abortAck` bits. The mailbox in flight is excluded: it completes normally and gets no abort acknowledge. An `abortAckClrWr` strobe clears the `abortAck` positions that are 1 in `abortAckClrMask`.
- R8: On completion, if `intMask[txIndex]` is 1, then `mbIrq` becomes 1 and `irqIndex` takes the 5-bit mailbox index. If the mask bit is 0, `mbIrq` is left unchanged. `irqClrWr` clears `mbIrq`.
- R9: After reset, `txReq`, `pending`, `ackBits`, `abortAck`, `mbIrq` and `irqIndex` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mbEnable | input | 32 | Per-mailbox enable |
| mbDirection | input | 32 | Per-mailbox direction, 1 = receive |
| ctrlWords | input | 448 | 32 control words of 14 bits; word i sits at bits i*14 +: 14, priority in bits 13:8 |
| intMask | input | 32 | Per-mailbox interrupt mask |
| setWr | input | 1 | Transmit set-request strobe |
| setMask | input | 32 | Mailboxes to mark pending |
| abortWr | input | 1 | Abort request strobe |
| abortMask | input | 32 | Mailboxes to abort |
| ackClrWr | input | 1 | Acknowledge clear strobe |
| ackClrMask | input | 32 | Write-one-to-clear mask for ackBits |
| abortAckClrWr | input | 1 | Abort acknowledge clear strobe |
| abortAckClrMask | input | 32 | Write-one-to-clear mask for abortAck |
| irqClrWr | input | 1 | Clears the mailbox interrupt flag |
| txDone | input | 1 | Serializer reports the frame finished |
| txReq | output | 1 | Frame in flight, offered to the serializer |
| txIndex | output | 5 | Mailbox being sent |
| pending | output | 32 | Pending transmit requests |
| ackBits | output | 32 | Transmit acknowledge bits |
| abortAck | output | 32 | Abort acknowledge bits |
| mbIrq | output | 1 | Global mailbox interrupt flag |
| irqIndex | output | 5 | Index of the mailbox that raised the flag |

## Verification
The hardest situation to reach is contention with a frame already in flight. It covers two cases: a higher-priority request that lands after selection, and an abort that names the in-flight mailbox. The stimulus first starts a low-priority frame and holds `txDone` low. While the frame is held, it sets a stronger mailbox or aborts every mailbox, including the one being sent. It then checks that the index is held, that the in-flight frame gets an acknowledge but no abort acknowledge, and that the stronger request wins the very next selection. A vector table covers the ordering rules by driving the priority fields from four schemes: all equal, rising with index, falling with index, and tied in pairs.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  localparam int NUM_MB   = 32;
  localparam int PRIO_W   = 6;
  localparam int PRIO_LSB = 8;
  localparam int CTRL_W   = 14;
  localparam int IDX_W    = $clog2(NUM_MB);

  typedef struct packed {
    logic startTx;
    logic finishTx;
  } txStrobes_t;
endpackage

// File: rtl/mbPrioPicker.sv
module mbPrioPicker
  import txarb_pkg::*;
#(
  parameter int N     = NUM_MB,
  parameter int PW    = PRIO_W,
  parameter int PLSB  = PRIO_LSB,
  parameter int CW    = CTRL_W,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*CW-1:0] ctrlFlat,
  output logic            winValid,
  output logic [IW-1:0]   winIdx
);
  logic [PW-1:0] prioArr [N];

  for (genvar g = 0; g < N; g++) begin : gPrio
    assign prioArr[g] = ctrlFlat[g*CW+PLSB +: PW];
  end

  logic [PW-1:0] bestPrio;

  // Ascending scan with >= lets a later (higher) index take a tie.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!winValid || prioArr[i] >= bestPrio)) begin
        winValid = 1'b1;
        bestPrio = prioArr[i];
        winIdx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/txCtrl.sv
module txCtrl
  import txarb_pkg::*;
#(
  parameter int N   = NUM_MB,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          winValid,
  input  logic [IW-1:0] winIdx,
  input  logic          txDone,
  output logic          busy,
  output logic [IW-1:0] curIdx,
  output txStrobes_t    strobes
);
  always_comb begin
    strobes.startTx  = !busy && winValid;
    strobes.finishTx = busy && txDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      curIdx <= '0;
    end else if (strobes.startTx) begin
      busy   <= 1'b1;
      curIdx <= winIdx;
    end else if (strobes.finishTx) begin
      busy   <= 1'b0;
    end
  end
endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import txarb_pkg::*;
#(
  parameter int N   = NUM_MB,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  mbEnable,
  input  logic [N-1:0]  mbDirection,
  input  logic [N-1:0]  intMask,
  input  logic          setWr,
  input  logic [N-1:0]  setMask,
  input  logic          abortWr,
  input  logic [N-1:0]  abortMask,
  input  logic          ackClrWr,
  input  logic [N-1:0]  ackClrMask,
  input  logic          abortAckClrWr,
  input  logic [N-1:0]  abortAckClrMask,
  input  logic          irqClrWr,
  input  txStrobes_t    strobes,
  input  logic          busy,
  input  logic [IW-1:0] curIdx,
  output logic [N-1:0]  candidates,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  ackBits,
  output logic [N-1:0]  abortAck,
  output logic          mbIrq,
  output logic [IW-1:0] irqIndex
);
  logic [N-1:0] curBit, doneBit, abortHit, setBits;

  always_comb begin
    curBit   = busy ? (N'(1) << curIdx) : '0;
    doneBit  = strobes.finishTx ? (N'(1) << curIdx) : '0;
    setBits  = setWr ? setMask : '0;
    abortHit = abortWr ? (abortMask & pending & ~curBit) : '0;
    // A mailbox aborted this cycle must not be picked this cycle.
    candidates = pending & mbEnable & ~mbDirection & ~abortHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      ackBits  <= '0;
      abortAck <= '0;
      mbIrq    <= 1'b0;
      irqIndex <= '0;
    end else begin
      pending  <= (pending | setBits) & ~abortHit & ~doneBit;
      ackBits  <= (ackBits & ~(ackClrWr ? ackClrMask : '0)) | doneBit;
      abortAck <= (abortAck & ~(abortAckClrWr ? abortAckClrMask : '0)) | abortHit;
      if (strobes.finishTx && intMask[curIdx]) begin
        mbIrq    <= 1'b1;
        irqIndex <= curIdx;
      end else if (irqClrWr) begin
        mbIrq    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txMailboxArbiter.sv
module txMailboxArbiter
  import txarb_pkg::*;
#(
  parameter int N   = NUM_MB,
  parameter int CW  = CTRL_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  mbEnable,
  input  logic [N-1:0]  mbDirection,
  input  logic [N*CW-1:0] ctrlWords,
  input  logic [N-1:0]  intMask,
  input  logic          setWr,
  input  logic [N-1:0]  setMask,
  input  logic          abortWr,
  input  logic [N-1:0]  abortMask,
  input  logic          ackClrWr,
  input  logic [N-1:0]  ackClrMask,
  input  logic          abortAckClrWr,
  input  logic [N-1:0]  abortAckClrMask,
  input  logic          irqClrWr,
  input  logic          txDone,
  output logic          txReq,
  output logic [IW-1:0] txIndex,
  output logic [N-1:0]  pending,
  output logic [N-1:0]  ackBits,
  output logic [N-1:0]  abortAck,
  output logic          mbIrq,
  output logic [IW-1:0] irqIndex
);
  logic          winValid;
  logic [IW-1:0] winIdx;
  logic          busy;
  logic [IW-1:0] curIdx;
  logic [N-1:0]  candidates;
  txStrobes_t    strobes;

  mbPrioPicker #(.N(N), .CW(CW)) i_picker (
    .cand(candidates), .ctrlFlat(ctrlWords),
    .winValid(winValid), .winIdx(winIdx)
  );

  txCtrl #(.N(N)) i_ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winIdx(winIdx),
    .txDone(txDone), .busy(busy), .curIdx(curIdx), .strobes(strobes)
  );

  txDatapath #(.N(N)) i_dp (
    .clk(clk), .rstN(rstN), .mbEnable(mbEnable), .mbDirection(mbDirection),
    .intMask(intMask), .setWr(setWr), .setMask(setMask),
    .abortWr(abortWr), .abortMask(abortMask),
    .ackClrWr(ackClrWr), .ackClrMask(ackClrMask),
    .abortAckClrWr(abortAckClrWr), .abortAckClrMask(abortAckClrMask),
    .irqClrWr(irqClrWr), .strobes(strobes), .busy(busy), .curIdx(curIdx),
    .candidates(candidates), .pending(pending), .ackBits(ackBits),
    .abortAck(abortAck), .mbIrq(mbIrq), .irqIndex(irqIndex)
  );

  assign txReq   = busy;
  assign txIndex = curIdx;
endmodule

// File: rtl/txArbChecker.sv
module txArbChecker #(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  mbEnable,
  input logic [N-1:0]  mbDirection,
  input logic [N-1:0]  intMask,
  input logic          txDone,
  input logic          txReq,
  input logic [IW-1:0] txIndex,
  input logic [N-1:0]  pending,
  input logic [N-1:0]  ackBits,
  input logic [N-1:0]  abortAck,
  input logic          mbIrq,
  input logic [IW-1:0] irqIndex
);
  assert_pick_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> pending[txIndex] && $past(mbEnable[txIndex]) && !$past(mbDirection[txIndex]));

  assert_hold_inflight_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq && $stable(txIndex));

  assert_done_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txDone |=> ackBits[$past(txIndex)] && !pending[$past(txIndex)] && !txReq);

  assert_no_abort_inflight_R7: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txDone && !abortAck[txIndex] |=> !abortAck[$past(txIndex)]);

  assert_irq_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txDone && intMask[txIndex] |=> mbIrq && irqIndex == $past(txIndex));
endmodule

bind txMailboxArbiter txArbChecker #(.N(N)) i_chk (
  .clk(clk), .rstN(rstN), .mbEnable(mbEnable), .mbDirection(mbDirection),
  .intMask(intMask), .txDone(txDone), .txReq(txReq), .txIndex(txIndex),
  .pending(pending), .ackBits(ackBits), .abortAck(abortAck),
  .mbIrq(mbIrq), .irqIndex(irqIndex)
);

// File: tb/test_txMailboxArbiter.sv
`timescale 1ns/1ps
module test_txMailboxArbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] mbEnable = '0, mbDirection = '0, intMask = '0;
  logic [447:0] ctrlWords = '0;
  logic setWr = 0, abortWr = 0, ackClrWr = 0, abortAckClrWr = 0, irqClrWr = 0, txDone = 0;
  logic [31:0] setMask = '0, abortMask = '0, ackClrMask = '0, abortAckClrMask = '0;
  logic txReq, mbIrq;
  logic [4:0] txIndex, irqIndex;
  logic [31:0] pending, ackBits, abortAck;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txMailboxArbiter i_txMailboxArbiter (
    .clk(clk), .rstN(rstN), .mbEnable(mbEnable), .mbDirection(mbDirection),
    .ctrlWords(ctrlWords), .intMask(intMask), .setWr(setWr), .setMask(setMask),
    .abortWr(abortWr), .abortMask(abortMask), .ackClrWr(ackClrWr), .ackClrMask(ackClrMask),
    .abortAckClrWr(abortAckClrWr), .abortAckClrMask(abortAckClrMask), .irqClrWr(irqClrWr),
    .txDone(txDone), .txReq(txReq), .txIndex(txIndex), .pending(pending),
    .ackBits(ackBits), .abortAck(abortAck), .mbIrq(mbIrq), .irqIndex(irqIndex)
  );

  typedef struct packed {
    logic [1:0]  scheme;
    logic [31:0] en;
    logic [31:0] dir;
    logic [31:0] set;
    logic [4:0]  exp;
  } vec_t;

  // scheme 0: all equal; 1: prio = index; 2: prio = 63 - index; 3: prio = index/2
  localparam vec_t VECS [6] = '{
    '{2'd0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0111, 5'd8},   // R3 tie
    '{2'd2, 32'hFFFF_FFFF, 32'h0, 32'h0000_0111, 5'd0},   // R2 low index wins by level
    '{2'd1, 32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 5'd31},  // R2
    '{2'd2, 32'hFFFF_FFFF, 32'h1, 32'h0000_0003, 5'd1},   // R1 receive excluded
    '{2'd3, 32'hFFFF_FFFF, 32'h0, 32'h0000_0030, 5'd5},   // R3 pair tie
    '{2'd2, 32'hFFFF_FFFE, 32'h0, 32'h0000_0005, 5'd2}    // R1 disabled excluded
  };

  function automatic logic [447:0] buildCtrl(input logic [1:0] scheme);
    logic [447:0] w = '0;
    for (int i = 0; i < 32; i++) begin
      logic [5:0] p;
      case (scheme)
        2'd0: p = 6'd5;
        2'd1: p = 6'(i);
        2'd2: p = 6'(63 - i);
        default: p = 6'(i / 2);
      endcase
      // low byte filled with noise that must not affect selection
      w[i*14 +: 14] = {p, 8'(8'h9F ^ 8'(i))};
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doSet(input logic [31:0] m);
    setMask = m; setWr = 1; @(negedge clk); setWr = 0; setMask = '0;
  endtask
  task automatic doAbort(input logic [31:0] m);
    abortMask = m; abortWr = 1; @(negedge clk); abortWr = 0; abortMask = '0;
  endtask
  task automatic doDone();
    txDone = 1; @(negedge clk); txDone = 0;
  endtask
  task automatic clearAll();
    ackClrMask = '1; abortAckClrMask = '1; ackClrWr = 1; abortAckClrWr = 1; irqClrWr = 1;
    @(negedge clk);
    ackClrWr = 0; abortAckClrWr = 0; irqClrWr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 txReq", 32'(txReq), 0);
    chk("R9 pending", pending, 0);
    chk("R9 ackBits", ackBits, 0);
    chk("R9 abortAck", abortAck, 0);
    chk("R9 irq", {26'(0), mbIrq, irqIndex}, 0);
    rstN = 1;
    @(negedge clk);

    intMask = '1;
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      mbEnable = v.en; mbDirection = v.dir; ctrlWords = buildCtrl(v.scheme);
      doSet(v.set);
      @(negedge clk);
      chk($sformatf("R2/R3 vec%0d txReq", k), 32'(txReq), 1);
      chk($sformatf("R2/R3 vec%0d txIndex", k), 32'(txIndex), 32'(v.exp));
      doAbort('1);
      chk($sformatf("R7 vec%0d abortAck", k), abortAck, v.set & ~(32'h1 << v.exp));
      chk($sformatf("R5 vec%0d held", k), 32'(txIndex), 32'(v.exp));
      doDone();
      chk($sformatf("R6 vec%0d ackBits", k), ackBits, 32'h1 << v.exp);
      chk($sformatf("R6 vec%0d pending", k), pending, 0);
      chk($sformatf("R8 vec%0d irq", k), {26'(0), mbIrq, irqIndex}, {26'(0), 1'b1, v.exp});
      clearAll();
    end

    // R5: stronger request while a frame is in flight waits
    mbEnable = '1; mbDirection = '0; ctrlWords = buildCtrl(2'd1);
    doSet(32'h8);
    @(negedge clk);
    chk("R5 first index", 32'(txIndex), 3);
    doSet(32'h4000_0000);
    @(negedge clk);
    chk("R5 not preempted", 32'(txIndex), 3);
    chk("R5 still busy", 32'(txReq), 1);
    doDone();
    chk("R5 idle after done", 32'(txReq), 0);
    @(negedge clk);
    chk("R5 next selection", {26'(0), txReq, txIndex}, {26'(0), 1'b1, 5'd30});
    doDone();
    // R6 partial write-one clear
    ackClrMask = 32'h8; ackClrWr = 1; @(negedge clk); ackClrWr = 0;
    chk("R6 partial ack clear", ackBits, 32'h4000_0000);
    clearAll();

    // R8: mask bit 0 leaves flag low
    intMask = ~32'h80;
    doSet(32'h80);
    @(negedge clk);
    doDone();
    chk("R8 masked no irq", 32'(mbIrq), 0);
    chk("R8 masked ack", ackBits, 32'h80);
    clearAll();
    chk("R6 ack cleared", ackBits, 0);

    // R4/R1: set accumulates; disabled mailboxes are never selected
    mbEnable = '0;
    doSet(32'h4);
    doSet(32'h200);
    @(negedge clk);
    chk("R4 pending accumulates", pending, 32'h204);
    chk("R1 disabled no txReq", 32'(txReq), 0);
    doAbort('1);
    chk("R7 idle abort ack", abortAck, 32'h204);
    chk("R7 idle abort pending", pending, 0);
    abortAckClrMask = 32'h4; abortAckClrWr = 1; @(negedge clk); abortAckClrWr = 0;
    chk("R7 partial abortAck clear", abortAck, 32'h200);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule